// File: doc/BRIEF.md
# Flash Bus Operation and Mode Controller

This block is the control side of a parallel boot-block flash device. It decodes the four active-low control pins (reset/power-down, chip enable, output enable and write enable) into one bus operation per cycle. From that operation it drives the enables for the two byte lanes of the data bus and a select that picks which internal source (array, identifier, status or query) a read presents.

Commands arrive as bytes on the low data lines and are taken on the rising edge of write enable while the chip is selected. They pick the read mode, clear error bits, or start a program or erase. A program or erase is modelled as a busy timer that clears the ready bit of an 8-bit status register while it runs. Leaving reset starts two wake-up counters, measured in clock cycles. Reads stay undriven until the first one expires. Writes are refused until the second one expires.

Top module: `flash_busctl`

## Requirements
- R1: `bus_op` gives the decoded operation: 0 reset (whenever `rp_n` is low, whatever the other pins), 1 standby (`ce_n` high), 2 output disable (`oe_n` and `we_n` high), 3 read (`oe_n` low, `we_n` high), 4 write (`we_n` low, `oe_n` high), 5 conflict (`oe_n` and `we_n` both low).
- R2: `dq_oe[0]` is high only during a read. `dq_oe[1]` is high only during a read with `word_mode` high. In standby both stay low whatever the level of `oe_n`.
- R3: After `rp_n` rises, `dq_oe` stays low for the first RD_WAKE clock edges. It may go high from the RD_WAKE-th edge on.
- R4: A WE rising edge seen while fewer than WR_WAKE edges have passed since `rp_n` rose is ignored and sets `wr_early`. `wr_early` stays set until the next reset.
- R5: A command is taken when `we_n` rises with `ce_n` low. The bytes FFh, 90h, 70h and 98h set `dq_sel` to 0 (array), 1 (identifier), 2 (status) and 3 (query).
- R6: While `rp_n` is low, `status` is 80h, `dq_sel` is 0, `busy` is low and `wr_early` is low. Any operation in progress is abandoned.
- R7: The write that follows 40h starts a program and the write that follows 20h starts an erase. Either one raises `busy` for exactly PROG_CYC or ERASE_CYC cycles, holds `status[7]` low for that time and sets `dq_sel` to 2.
- R8: When the busy timer ends, `status` reads 80h and `dq_sel` stays 2 (status).
- R9: Taking `ce_n` high during a program or erase does not shorten it.
- R10: Commands written while `busy` is high are ignored.
- R11: A command byte outside the defined set sets `status[4]`. The byte 50h clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for sampling the pins and running the counters |
| rp_n | input | 1 | Active-low reset / deep power-down, asynchronous assert |
| ce_n | input | 1 | Active-low chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| word_mode | input | 1 | 1 = 16-bit bus, 0 = 8-bit bus |
| cmd_in | input | 8 | Command byte from the low data lines |
| bus_op | output | 3 | Decoded bus operation (R1 encoding) |
| dq_oe | output | 2 | Output enable for the low and high byte lanes |
| dq_sel | output | 2 | Read source: 0 array, 1 identifier, 2 status, 3 query |
| status | output | 8 | Status register: bit 7 ready, bit 4 command error |
| busy | output | 1 | Program or erase in progress |
| wr_early | output | 1 | A write arrived inside the write wake-up window |

## Verification
Two cases put functions in the same cycle. In the first, the chip is deselected while the busy timer runs. The bench measures the busy length with `ce_n` high and checks it against PROG_CYC, and it confirms that `dq_oe` stays low throughout. In the second, reset arrives in the middle of an erase. The bench drops `rp_n` partway through an erase and expects `busy` to fall at once, with status 80h and array mode, all checked before the next clock edge. A write issued during a program is checked to leave the read source unchanged.

// File: rtl/flash_busctl.sv
module flash_busctl #(
  parameter int RD_WAKE   = 4,
  parameter int WR_WAKE   = 6,
  parameter int PROG_CYC  = 16,
  parameter int ERASE_CYC = 64
) (
  input  logic       clk,
  input  logic       rp_n,
  input  logic       ce_n,
  input  logic       oe_n,
  input  logic       we_n,
  input  logic       word_mode,
  input  logic [7:0] cmd_in,
  output logic [2:0] bus_op,
  output logic [1:0] dq_oe,
  output logic [1:0] dq_sel,
  output logic [7:0] status,
  output logic       busy,
  output logic       wr_early
);
  localparam int OP_MAX = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
  localparam int CW = $clog2(OP_MAX + 2);
  localparam int RW = $clog2(RD_WAKE + 2);
  localparam int WW = $clog2(WR_WAKE + 2);

  localparam logic [2:0] OP_RST = 3'd0, OP_SBY = 3'd1, OP_ODIS = 3'd2,
                         OP_RD = 3'd3, OP_WR = 3'd4, OP_BAD = 3'd5;

  typedef enum logic [1:0] {M_ARR, M_ID, M_STAT, M_QRY} mode_t;
  typedef enum logic [1:0] {P_NONE, P_PROG, P_ERASE} pend_t;

  mode_t         mode;
  pend_t         pend;
  logic [CW-1:0] op_cnt;
  logic [RW-1:0] rd_cnt;
  logic [WW-1:0] wr_cnt;
  logic          we_q;

  always_comb begin
    if (!rp_n)               bus_op = OP_RST;
    else if (ce_n)           bus_op = OP_SBY;
    else if (!oe_n && !we_n) bus_op = OP_BAD;
    else if (!oe_n)          bus_op = OP_RD;
    else if (!we_n)          bus_op = OP_WR;
    else                     bus_op = OP_ODIS;
  end

  wire rd_ready = (rd_cnt == '0);
  wire wr_ready = (wr_cnt == '0);
  wire we_rise  = !we_q && we_n && !ce_n;
  wire wr_take  = we_rise && wr_ready;
  wire rd_on    = (bus_op == OP_RD) && rd_ready;

  assign busy   = (op_cnt != '0);
  assign dq_sel = mode;
  assign dq_oe  = {rd_on && word_mode, rd_on};

  always_ff @(posedge clk or negedge rp_n) begin
    if (!rp_n) begin
      mode     <= M_ARR;
      pend     <= P_NONE;
      op_cnt   <= '0;
      rd_cnt   <= RW'(RD_WAKE);
      wr_cnt   <= WW'(WR_WAKE);
      we_q     <= 1'b1;
      status   <= 8'h80;
      wr_early <= 1'b0;
    end else begin
      we_q <= we_n;
      if (!rd_ready) rd_cnt <= rd_cnt - 1'b1;
      if (!wr_ready) wr_cnt <= wr_cnt - 1'b1;
      if (we_rise && !wr_ready) wr_early <= 1'b1;
      if (busy) begin
        op_cnt <= op_cnt - 1'b1;
        if (op_cnt == CW'(1)) begin
          status[7] <= 1'b1;
          mode      <= M_STAT;
        end
      end else if (wr_take) begin
        if (pend != P_NONE) begin
          op_cnt    <= (pend == P_PROG) ? CW'(PROG_CYC) : CW'(ERASE_CYC);
          status[7] <= 1'b0;
          mode      <= M_STAT;
          pend      <= P_NONE;
        end else begin
          case (cmd_in)
            8'hFF:   mode <= M_ARR;
            8'h90:   mode <= M_ID;
            8'h70:   mode <= M_STAT;
            8'h98:   mode <= M_QRY;
            8'h40:   pend <= P_PROG;
            8'h20:   pend <= P_ERASE;
            8'h50:   status[4] <= 1'b0;
            default: status[4] <= 1'b1;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/flash_busctl_chk.sv
module flash_busctl_chk (
  input logic       clk,
  input logic       rp_n,
  input logic       ce_n,
  input logic [2:0] bus_op,
  input logic [1:0] dq_oe,
  input logic [1:0] dq_sel,
  input logic [7:0] status,
  input logic       busy,
  input logic       wr_early
);
  a_r1_reset_wins: assert property (@(posedge clk) !rp_n |-> bus_op == 3'd0);
  a_r2_standby_hiz: assert property (@(posedge clk) disable iff (!rp_n)
    ce_n |-> dq_oe == 2'b00);
  a_r6_reset_state: assert property (@(posedge clk)
    $rose(rp_n) |-> (status == 8'h80 && dq_sel == 2'd0 && !busy));
  a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (!rp_n)
    busy |-> !status[7]);
  a_r10_mode_held: assert property (@(posedge clk) disable iff (!rp_n)
    (busy && $past(busy)) |-> $stable(dq_sel));
  a_r4_early_sticky: assert property (@(posedge clk) disable iff (!rp_n)
    $past(wr_early) |-> wr_early);
endmodule

bind flash_busctl flash_busctl_chk chk_i (
  .clk(clk), .rp_n(rp_n), .ce_n(ce_n), .bus_op(bus_op), .dq_oe(dq_oe),
  .dq_sel(dq_sel), .status(status), .busy(busy), .wr_early(wr_early)
);

// File: tb/flash_busctl_test.sv
module flash_busctl_test;
  localparam int RDW = 3, WRW = 5, PC = 6, EC = 10;

  logic clk = 1'b0;
  logic rp_n = 1'b1, ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1, word_mode = 1'b1;
  logic [7:0] cmd_in = 8'hFF;
  logic [2:0] bus_op;
  logic [1:0] dq_oe, dq_sel;
  logic [7:0] status;
  logic busy, wr_early;
  int vectors = 0, bad = 0;

  always #2 clk = ~clk;

  flash_busctl #(.RD_WAKE(RDW), .WR_WAKE(WRW), .PROG_CYC(PC), .ERASE_CYC(EC)) uut (
    .clk(clk), .rp_n(rp_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .word_mode(word_mode), .cmd_in(cmd_in), .bus_op(bus_op), .dq_oe(dq_oe),
    .dq_sel(dq_sel), .status(status), .busy(busy), .wr_early(wr_early));

  task automatic chk(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic write_cmd(input logic [7:0] b);
    @(negedge clk); ce_n = 0; oe_n = 1; we_n = 0; cmd_in = b;
    @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 1; #1;
  endtask

  function automatic int exp_op(input logic c, input logic o, input logic w);
    if (c) return 1;
    if (!o && !w) return 5;
    if (!o) return 3;
    if (!w) return 4;
    return 2;
  endfunction

  initial begin
    #400000;
    bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end

  initial begin
    int n;
    #1 rp_n = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk); {ce_n, oe_n, we_n} = 3'(i); #1;
      chk("R1 reset op", bus_op, 0);
      chk("R2 reset hiz", dq_oe, 0);
      chk("R6 reset state", {status, dq_sel, busy, wr_early}, {8'h80, 2'd0, 1'b0, 1'b0});
    end
    // R3 read wake-up
    @(negedge clk); ce_n = 0; oe_n = 0; we_n = 1; rp_n = 1;
    for (int k = 1; k <= 4; k++) begin
      @(posedge clk); #1;
      chk("R3 read wake", dq_oe, (k >= RDW) ? 3 : 0);
    end
    repeat (3) @(negedge clk);
    // R1/R2 sweep with rp_n high, both bus widths
    cmd_in = 8'hFF;
    for (int wm = 0; wm < 2; wm++)
      for (int i = 0; i < 8; i++) begin
        @(negedge clk); word_mode = wm[0]; {ce_n, oe_n, we_n} = 3'(i); #1;
        chk("R1 decode", bus_op, exp_op(ce_n, oe_n, we_n));
        chk("R2 lane enable", dq_oe, (exp_op(ce_n, oe_n, we_n) == 3) ? (wm ? 3 : 1) : 0);
      end
    @(negedge clk); ce_n = 1; oe_n = 1; we_n = 1; word_mode = 1;
    // R5 read modes
    write_cmd(8'h90); chk("R5 identifier", dq_sel, 1);
    write_cmd(8'h98); chk("R5 query", dq_sel, 3);
    write_cmd(8'h70); chk("R5 status", dq_sel, 2);
    write_cmd(8'hFF); chk("R5 array", dq_sel, 0);
    @(negedge clk); ce_n = 0; oe_n = 1; we_n = 0; cmd_in = 8'h90; #1;
    chk("R1 write op", bus_op, 4);
    @(negedge clk); ce_n = 1; we_n = 1; @(negedge clk); #1;
    chk("R5 no take with ce high", dq_sel, 0);
    // R11 error bit
    write_cmd(8'h33); chk("R11 error set", status, 8'h90);
    chk("R11 mode kept", dq_sel, 0);
    write_cmd(8'h50); chk("R11 error clear", status, 8'h80);
    // R7/R8/R9 program, deselected during the run
    write_cmd(8'h40);
    chk("R7 setup idle", busy, 0);
    write_cmd(8'h55);
    chk("R7 busy", busy, 1);
    chk("R7 status low", status, 8'h00);
    chk("R7 mode status", dq_sel, 2);
    n = 0;
    while (busy && n < 100) begin
      @(negedge clk); #1; n++;
      if (busy) chk("R9 standby hiz", dq_oe, 0);
    end
    chk("R9 program length", n, PC);
    chk("R8 status ready", status, 8'h80);
    chk("R8 mode status", dq_sel, 2);
    // R10 write during busy
    write_cmd(8'hFF);
    write_cmd(8'h40);
    write_cmd(8'h11);
    write_cmd(8'hFF);
    chk("R10 still busy", busy, 1);
    chk("R10 mode kept", dq_sel, 2);
    while (busy) @(negedge clk);
    #1 chk("R10 status after", status, 8'h80);
    // R7 erase then R6 reset mid-operation
    write_cmd(8'hFF);
    write_cmd(8'h20);
    write_cmd(8'hD0);
    chk("R7 erase busy", busy, 1);
    repeat (3) @(negedge clk);
    rp_n = 0; #1;
    chk("R6 abort busy", busy, 0);
    chk("R6 abort status", status, 8'h80);
    chk("R6 abort mode", dq_sel, 0);
    // R4 write inside the write wake window
    @(negedge clk); ce_n = 0; oe_n = 1; we_n = 0; cmd_in = 8'h90; rp_n = 1;
    @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 1; #1;
    chk("R4 early flag", wr_early, 1);
    chk("R4 early ignored", dq_sel, 0);
    repeat (8) @(negedge clk);
    write_cmd(8'h90);
    chk("R4 accepted after window", dq_sel, 1);
    chk("R4 flag sticky", wr_early, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, bad);
    $finish;
  end
endmodule